// File: doc/BRIEF.md
# Parallel-to-Serial TDM Interleaver

This block takes a byte-wide time-division bus that carries 1024 byte slots per frame and spreads those bytes across a set of serial streams. The bytes are interleaved, so consecutive parallel slots land on consecutive streams. Two line formats are available. In the low-rate format the bytes go to 32 streams of 32 channels each. In the high-rate format they go to 16 streams of 64 channels each, and the upper 16 streams stay silent. Each parallel slot lasts two master clock cycles. A serial bit lasts 8 master cycles in the low-rate format and 4 in the high-rate format.

Incoming bytes are collected into one of two banks. Each bank holds one serial channel's worth of bytes, one byte for each active stream, together with a per-byte disable flag. While one bank fills from the parallel bus, the other bank is shifted out, most significant bit first. A byte therefore appears on its stream during the channel time after the one in which it arrived. A phase input selects whether the byte and its disable flag are taken in the first or the second cycle of each slot. A frame pulse from the timing generator realigns the internal slot counter. Each stream has a data bit and an enable bit. The enable bit can be dropped for single channel slots, and it drives an output driver outside this block.

Top module: `tdm_p2s_top`

## Requirements
- R1: The internal frame position advances by one per clock, and wraps after 2048 cycles (1024 slots of 2 cycles). Without a new frame pulse, the output mapping repeats with a period of exactly 2048 cycles.
- R2: With `late_phase`=0, `par_byte` and `slot_off` are taken in the first cycle of each slot (even frame position). With `late_phase`=1 they are taken in the second cycle (odd position). Values presented in the other cycle have no effect on the outputs.
- R3: With `rate_hi`=0, slot n (counting from the frame pulse) goes to stream n mod 32. Its serial channel is n div 32, and each channel occupies 64 cycles. Stream k is bit k of `ser_data` and `ser_en`.
- R4: With `rate_hi`=1, slot n goes to stream n mod 16, and each of the 64 channels occupies 32 cycles. Bits 31..16 of `ser_data` and `ser_en` stay 0.
- R5: Each byte is sent bit 7 first and bit 0 last. A bit lasts 8 cycles when `rate_hi`=0 and 4 cycles when `rate_hi`=1. Outputs change only on bit boundaries.
- R6: Latency is one channel time. Bytes that arrive during channel c are sent during channel c+1. Channel 0 of a frame carries the last group of bytes of the previous frame.
- R7: When `slot_off`=1 is taken with a byte, `ser_en` is 0 on that byte's stream for the whole channel the byte occupies. Whenever `ser_en` is 0, the `ser_data` bit is 0.
- R8: After reset, every `ser_en` and `ser_data` bit is 0 for at least the first channel time.
- R9: A frame pulse makes the next cycle frame position 0, from any current position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock (two cycles per parallel slot) |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Frame pulse; the next cycle is frame position 0 |
| par_byte | input | 8 | Parallel byte bus |
| rate_hi | input | 1 | 0: 32 streams x 32 channels; 1: 16 streams x 64 channels |
| late_phase | input | 1 | 0: sample in first slot cycle; 1: sample in second slot cycle |
| slot_off | input | 1 | 1 disables the serial slot of the byte taken with it |
| ser_data | output | 32 | Serial data bit for each stream |
| ser_en | output | 32 | Output-driver enable for each stream |

## Verification
The bench presents different values of the byte and the disable flag in the two cycles of every slot. A design that samples in the wrong phase then sends the wrong bytes and masks the wrong channels. Each configuration runs across a frame wrap, which exposes three kinds of fault: a design that drops the previous frame's last group into channel 0, one that swaps the ping-pong banks, or one that uses the wrong stream modulus. The high-rate runs check that the upper sixteen streams stay silent and that each bit lasts four cycles rather than eight. Every run begins mid-frame with a frame pulse, so a design that ignores a resync misplaces every byte.

// File: rtl/tdm_p2s_pkg.sv
package tdm_p2s_pkg;
    localparam int unsigned P_STREAMS = 32;
    localparam int unsigned P_BYTE_W  = 8;
    localparam int unsigned P_SLOTS   = 1024;

    typedef enum logic {
        RATE_LO = 1'b0,
        RATE_HI = 1'b1
    } rate_e;
endpackage

// File: rtl/tdm_p2s_timebase.sv
module tdm_p2s_timebase
    import tdm_p2s_pkg::*;
#(
    parameter int unsigned NUM_STREAMS = P_STREAMS,
    parameter int unsigned BYTE_W      = P_BYTE_W,
    parameter int unsigned SLOTS       = P_SLOTS,
    localparam int unsigned CNT_W      = $clog2(SLOTS * 2),
    localparam int unsigned IDX_W      = $clog2(NUM_STREAMS),
    localparam int unsigned BIT_W      = $clog2(BYTE_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             rate_hi,
    input  logic             late_phase,
    output logic [CNT_W-1:0] pos,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic             wr_bank,
    output logic [BIT_W-1:0] rd_bit
);
    localparam int unsigned GRP_W = IDX_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tb_state_t;

    tb_state_t st_d, st_q;
    logic [BIT_W-1:0] bit_fld;
    rate_e rate;

    // R1 R9: free-running frame position, restarted by the frame pulse
    always_comb begin
        st_d = st_q;
        if (frame_start) st_d.cnt = '0;
        else             st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2 R3 R4 R5: slot decode, bank select and bit position
    always_comb begin
        rate   = rate_e'(rate_hi);
        pos    = st_q.cnt;
        wr_en  = (st_q.cnt[0] == late_phase);
        if (rate == RATE_HI) begin
            wr_idx  = {1'b0, st_q.cnt[IDX_W-1:1]};
            wr_bank = st_q.cnt[GRP_W-1];
            bit_fld = st_q.cnt[GRP_W-2 -: BIT_W];
        end else begin
            wr_idx  = st_q.cnt[IDX_W:1];
            wr_bank = st_q.cnt[GRP_W];
            bit_fld = st_q.cnt[GRP_W-1 -: BIT_W];
        end
        rd_bit = BIT_W'(BYTE_W - 1) - bit_fld;
    end
endmodule

// File: rtl/tdm_p2s_bank.sv
module tdm_p2s_bank
    import tdm_p2s_pkg::*;
#(
    parameter int unsigned NUM_STREAMS = P_STREAMS,
    parameter int unsigned BYTE_W      = P_BYTE_W,
    localparam int unsigned IDX_W      = $clog2(NUM_STREAMS)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               we,
    input  logic [IDX_W-1:0]                   idx,
    input  logic [BYTE_W-1:0]                  din,
    input  logic                               off_in,
    output logic [NUM_STREAMS-1:0][BYTE_W-1:0] bytes,
    output logic [NUM_STREAMS-1:0]             off
);
    typedef struct packed {
        logic [NUM_STREAMS-1:0][BYTE_W-1:0] bytes;
        logic [NUM_STREAMS-1:0]             off;
    } bank_state_t;

    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.bytes[idx] = din;
            st_d.off[idx]   = off_in;
        end
    end

    // R8: slots start disabled until written
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.bytes <= '0;
            st_q.off   <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign bytes = st_q.bytes;
    assign off   = st_q.off;
endmodule

// File: rtl/tdm_p2s_serializer.sv
module tdm_p2s_serializer
    import tdm_p2s_pkg::*;
#(
    parameter int unsigned NUM_STREAMS = P_STREAMS,
    parameter int unsigned BYTE_W      = P_BYTE_W,
    localparam int unsigned BIT_W      = $clog2(BYTE_W)
) (
    input  logic [NUM_STREAMS-1:0][BYTE_W-1:0] bytes,
    input  logic [NUM_STREAMS-1:0]             off,
    input  logic [BIT_W-1:0]                   rd_bit,
    input  logic                               rate_hi,
    output logic [NUM_STREAMS-1:0]             ser_data,
    output logic [NUM_STREAMS-1:0]             ser_en
);
    localparam int unsigned HALF = NUM_STREAMS / 2;

    for (genvar k = 0; k < NUM_STREAMS; k++) begin : g_lane
        logic active;
        if (k >= HALF) begin : g_upper
            // R4: upper half silent in the high-rate format
            assign active = !rate_hi;
        end else begin : g_lower
            assign active = 1'b1;
        end
        // R5 R7: MSB-first bit select, data forced low when disabled
        always_comb begin
            ser_en[k]   = active && !off[k];
            ser_data[k] = ser_en[k] && bytes[k][rd_bit];
        end
    end
endmodule

// File: rtl/tdm_p2s_top.sv
module tdm_p2s_top
    import tdm_p2s_pkg::*;
#(
    parameter int unsigned NUM_STREAMS = P_STREAMS,
    parameter int unsigned BYTE_W      = P_BYTE_W,
    parameter int unsigned SLOTS       = P_SLOTS,
    localparam int unsigned CNT_W      = $clog2(SLOTS * 2),
    localparam int unsigned IDX_W      = $clog2(NUM_STREAMS),
    localparam int unsigned BIT_W      = $clog2(BYTE_W)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   frame_start,
    input  logic [BYTE_W-1:0]      par_byte,
    input  logic                   rate_hi,
    input  logic                   late_phase,
    input  logic                   slot_off,
    output logic [NUM_STREAMS-1:0] ser_data,
    output logic [NUM_STREAMS-1:0] ser_en
);
    logic [CNT_W-1:0] pos_w;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic             wr_bank;
    logic [BIT_W-1:0] rd_bit;

    logic [NUM_STREAMS-1:0][BYTE_W-1:0] bank_bytes [2];
    logic [NUM_STREAMS-1:0]             bank_off   [2];
    logic [NUM_STREAMS-1:0][BYTE_W-1:0] rd_bytes;
    logic [NUM_STREAMS-1:0]             rd_off;

    tdm_p2s_timebase #(
        .NUM_STREAMS(NUM_STREAMS), .BYTE_W(BYTE_W), .SLOTS(SLOTS)
    ) u_timebase (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .rate_hi(rate_hi), .late_phase(late_phase),
        .pos(pos_w), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_bank(wr_bank), .rd_bit(rd_bit)
    );

    // R6: ping-pong banks, one fills while the other drains
    for (genvar b = 0; b < 2; b++) begin : g_bank
        tdm_p2s_bank #(
            .NUM_STREAMS(NUM_STREAMS), .BYTE_W(BYTE_W)
        ) u_bank (
            .clk(clk), .rst_n(rst_n),
            .we(wr_en && (wr_bank == 1'(b))),
            .idx(wr_idx), .din(par_byte), .off_in(slot_off),
            .bytes(bank_bytes[b]), .off(bank_off[b])
        );
    end

    always_comb begin
        rd_bytes = wr_bank ? bank_bytes[0] : bank_bytes[1];
        rd_off   = wr_bank ? bank_off[0]   : bank_off[1];
    end

    tdm_p2s_serializer #(
        .NUM_STREAMS(NUM_STREAMS), .BYTE_W(BYTE_W)
    ) u_serializer (
        .bytes(rd_bytes), .off(rd_off), .rd_bit(rd_bit),
        .rate_hi(rate_hi), .ser_data(ser_data), .ser_en(ser_en)
    );
endmodule

// File: rtl/tdm_p2s_checker.sv
module tdm_p2s_checker #(
    parameter int unsigned NUM_STREAMS = 32,
    parameter int unsigned BYTE_W      = 8,
    parameter int unsigned CNT_W       = 11
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   frame_start,
    input logic                   rate_hi,
    input logic [CNT_W-1:0]       pos,
    input logic [NUM_STREAMS-1:0] ser_data,
    input logic [NUM_STREAMS-1:0] ser_en
);
    localparam int unsigned HALF = NUM_STREAMS / 2;
    localparam int unsigned LO_W = $clog2(2 * NUM_STREAMS / BYTE_W);

    logic [LO_W-1:0] low_bits;
    logic            last_of_bit;

    always_comb begin
        low_bits = pos[LO_W-1:0];
        if (rate_hi) low_bits[LO_W-1] = 1'b1;
        last_of_bit = &low_bits;
    end

    AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (pos == '0)); // R9

    AST_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> (pos == CNT_W'($past(pos) + 1'b1))); // R1

    AST_UPPER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        rate_hi |-> (ser_en[NUM_STREAMS-1:HALF] == '0 && ser_data[NUM_STREAMS-1:HALF] == '0)); // R4

    AST_DATA_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ((ser_data & ~ser_en) == '0)); // R7

    AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && !last_of_bit) |=>
            (!$stable(rate_hi) || ($stable(ser_data) && $stable(ser_en)))); // R5
endmodule

bind tdm_p2s_top tdm_p2s_checker #(
    .NUM_STREAMS(NUM_STREAMS), .BYTE_W(BYTE_W), .CNT_W(CNT_W)
) u_checker (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .rate_hi(rate_hi),
    .pos(pos_w), .ser_data(ser_data), .ser_en(ser_en)
);

// File: tb/tdm_p2s_top_bench.sv
module tdm_p2s_top_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        frame_start;
    logic [7:0]  par_byte;
    logic        rate_hi;
    logic        late_phase;
    logic        slot_off;
    logic [31:0] ser_data;
    logic [31:0] ser_en;

    always #2 clk = ~clk;

    tdm_p2s_top u_tdm_p2s_top (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .par_byte(par_byte), .rate_hi(rate_hi), .late_phase(late_phase),
        .slot_off(slot_off), .ser_data(ser_data), .ser_en(ser_en)
    );

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 0;

    logic [7:0] rec_byte [0:1023];
    logic       rec_off  [0:1023];
    int         p;
    int         since;
    logic       cfg_rate, cfg_late;
    logic [1:0] cfg_off;
    logic [7:0] cfg_seed;

    // row: [11] rate_hi, [10] late_phase, [9:8] disable mode, [7:0] seed
    localparam logic [11:0] ROWS [0:5] = '{
        12'h011, 12'h52A, 12'h933, 12'hC47, 12'h25C, 12'hD6E
    };

    function automatic logic [7:0] pat(int s, logic [7:0] seed, logic ph);
        return 8'(s * 29) ^ seed ^ (ph ? 8'hC3 : 8'h00);
    endfunction

    function automatic logic offv(int s, logic [1:0] m, logic [7:0] seed, logic ph);
        case (m)
            2'd0:    return 1'b0;
            2'd1:    return ((((s + int'(seed)) % 5) == 0) ? 1'b1 : 1'b0) ^ ph;
            default: return 1'b1;
        endcase
    endfunction

    // one cycle: compare at the falling edge, then drive the slot inputs
    task automatic step();
        int g_sz, cg, g, o, bi, s, src;
        logic [31:0] ed, ee;
        logic ph;
        @(negedge clk);
        g_sz = cfg_rate ? 16 : 32;
        cg   = 2 * g_sz;
        if (since >= cg) begin
            g  = p / cg;
            o  = p % cg;
            bi = 7 - o / (cg / 8);
            ed = '0;
            ee = '0;
            for (int k = 0; k < g_sz; k++) begin
                src   = (g > 0) ? (g - 1) * g_sz + k : 1024 - g_sz + k;
                ee[k] = !rec_off[src];
                ed[k] = ee[k] && rec_byte[src][bi];
            end
            n_vec++;
            // R1 R2 R3 R4 R5 R6 R7 R9 all fold into this per-cycle expectation
            if ({ser_en, ser_data} !== {ee, ed}) begin
                n_bad++;
                $display("FAIL %s pos=%0d rate=%0d late=%0d en=%h/%h data=%h/%h (got/exp)",
                         cfg_rate ? "R4 R5 R6 R2 R7" : "R3 R5 R6 R2 R7",
                         p, cfg_rate, cfg_late, ser_en, ee, ser_data, ed);
            end
        end
        s  = p / 2;
        ph = p[0];
        frame_start = 1'b0;
        par_byte    = pat(s, cfg_seed, ph);
        slot_off    = offv(s, cfg_off, cfg_seed, ph);
        if (ph == cfg_late) begin
            rec_byte[s] = pat(s, cfg_seed, ph);
            rec_off[s]  = offv(s, cfg_off, cfg_seed, ph);
        end
        p     = (p + 1) % 2048;
        since = since + 1;
    endtask

    // R9: every row opens with a frame pulse from wherever the counter is
    task automatic start_row(logic [11:0] row);
        @(negedge clk);
        cfg_rate    = row[11];
        cfg_late    = row[10];
        cfg_off     = row[9:8];
        cfg_seed    = row[7:0];
        rate_hi     = cfg_rate;
        late_phase  = cfg_late;
        frame_start = 1'b1;
        par_byte    = 8'h00;
        slot_off    = 1'b0;
        p     = 0;
        since = 0;
    endtask

    initial begin
        rst_n       = 1'b0;
        frame_start = 1'b0;
        par_byte    = 8'hA5;
        rate_hi     = 1'b0;
        late_phase  = 1'b0;
        slot_off    = 1'b0;
        cfg_rate = 1'b0; cfg_late = 1'b0; cfg_off = 2'd0; cfg_seed = 8'h00;
        p = 0; since = 0;
        repeat (3) @(negedge clk);
        // R8: reset state and first channel time stay silent
        for (int i = 0; i < 60; i++) begin
            n_vec++;
            if (ser_en !== 32'h0 || ser_data !== 32'h0) begin
                n_bad++;
                $display("FAIL R8 cycle=%0d en=%h data=%h expected 0/0", i, ser_en, ser_data);
            end
            if (i == 0) rst_n = 1'b1;
            @(negedge clk);
        end
        // table walk: each row covers two full frames (R1 wrap) plus an odd tail
        for (int r = 0; r < 6; r++) begin
            start_row(ROWS[r]);
            for (int c = 0; c < 2 * 2048 + 37; c++) step();
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule